// File: doc/BRIEF.md
# Latched Hexadecimal Seven-Segment Digit Driver

This block turns a 4-bit binary value into the seven segment drives of one display digit, with all sixteen hexadecimal symbols available (0 to 9, then A, b, C, d, E, F). The segment outputs are active high, so they suit a common-cathode display. An input register sits in front of the decoder. While the active-low track control is low, the register follows the data inputs. While it is high, the register keeps the last value it took in.

Zero suppression comes from a ripple chain. A digit whose stored value is zero, and whose ripple input is low, goes dark and pulls its own ripple output low. The neighbouring stage can then suppress its zero as well. To blank leading integer zeros, tie the top stage's ripple input low and chain the stages toward the decimal point. To blank trailing fraction zeros, build a second chain that runs in the other direction. Hold the ripple input high on any stage whose zero must always show.

A separate active-low force input blanks the digit at any value. Driving it with a duty-cycled signal sets the apparent brightness.

Top module: `hexdisp_digit`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) clears the stored value to zero. With zin_n high, the digit then shows the zero glyph.
- R2: Segment outputs are active high, with seg[0]=a through seg[6]=g (bit order gfedcba). The glyphs in hex are: 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F, A=77, b=7C, C=39, d=5E, E=79, F=71.
- R3: At every clock edge where track_n is low, din is loaded. The new glyph appears after that edge.
- R4: While track_n is high, changes on din have no effect on seg.
- R5: With a stored value of zero and zin_n low, seg is 0000000 and zout_n is low.
- R6: With a stored value of zero and zin_n high, the zero glyph is shown and zout_n stays high.
- R7: With a non-zero stored value, the glyph is shown and zout_n is high, whatever the level of zin_n.
- R8: When force_n is low, seg is 0000000 and zout_n is low, for any stored value and any zin_n.
- R9: Consider eight chained stages holding 0060.0300, with the integer chain starting from the top digit and the fraction chain starting from the bottom digit. Only 60.03 lights up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| track_n | input | 1 | Low: load din each clock; high: hold |
| din | input | 4 | Binary value to display |
| zin_n | input | 1 | Ripple-blank input, active low |
| force_n | input | 1 | External blank/dim, active low |
| seg | output | 7 | Segment drives a..g, active high |
| zout_n | output | 1 | Ripple-blank output, active low |

## Verification
The assertions check four things on every cycle: the register's load and hold behaviour, the forced blank, blanking of a zero when the ripple input is low, and that a non-blanked digit always lights at least one segment and keeps zout_n high. Only the bench scenarios can confirm the exact bit pattern of each of the sixteen glyphs, that the reset value shows as a lit zero, and that an eight-stage chain gives the combined 60.03 result across two ripple directions.

// File: rtl/hexdisp_pkg.sv
package hexdisp_pkg;
  localparam int VAL_W = 4;
  localparam int SEG_W = 7;
  typedef logic [VAL_W-1:0] val_t;
  typedef logic [SEG_W-1:0] seg_t;

  // segment pattern, bit 0 = a ... bit 6 = g
  function automatic seg_t hex_glyph(input val_t v);
    seg_t s;
    case (v)
      4'h0: s = 7'b0111111;
      4'h1: s = 7'b0000110;
      4'h2: s = 7'b1011011;
      4'h3: s = 7'b1001111;
      4'h4: s = 7'b1100110;
      4'h5: s = 7'b1101101;
      4'h6: s = 7'b1111101;
      4'h7: s = 7'b0000111;
      4'h8: s = 7'b1111111;
      4'h9: s = 7'b1101111;
      4'hA: s = 7'b1110111;
      4'hB: s = 7'b1111100;
      4'hC: s = 7'b0111001;
      4'hD: s = 7'b1011110;
      4'hE: s = 7'b1111001;
      default: s = 7'b1110001;
    endcase
    return s;
  endfunction

  function automatic logic zero_dark(input val_t v, input logic zin_n, input logic force_n);
    return (!zin_n && (v == '0)) || !force_n;
  endfunction
endpackage

// File: rtl/hexdisp_hold.sv
module hexdisp_hold
  import hexdisp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic track_n,
  input  val_t din,
  output val_t held
);
  always_ff @(posedge clk) begin
    if (!rst_n)        held <= '0;
    else if (!track_n) held <= din;
  end

  AST_LOAD_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    !track_n |=> held == $past(din)); // R3
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    track_n |=> $stable(held)); // R4
endmodule

// File: rtl/hexdisp_blank.sv
module hexdisp_blank
  import hexdisp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  val_t held,
  input  logic zin_n,
  input  logic force_n,
  output logic dark
);
  logic is_zero;
  assign is_zero = (held == '0);
  assign dark    = zero_dark(held, zin_n, force_n);

  AST_NONZERO_LIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_zero && force_n) |-> !dark); // R7
  AST_ZERO_OPEN_LIT: assert property (@(posedge clk) disable iff (!rst_n)
    (is_zero && zin_n && force_n) |-> !dark); // R6
endmodule

// File: rtl/hexdisp_digit.sv
module hexdisp_digit
  import hexdisp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       track_n,
  input  logic [3:0] din,
  input  logic       zin_n,
  input  logic       force_n,
  output logic [6:0] seg,
  output logic       zout_n
);
  val_t held;
  logic dark;
  seg_t glyph;

  hexdisp_hold u_hold (
    .clk(clk), .rst_n(rst_n), .track_n(track_n), .din(din), .held(held)
  );

  hexdisp_blank u_blank (
    .clk(clk), .rst_n(rst_n), .held(held), .zin_n(zin_n),
    .force_n(force_n), .dark(dark)
  );

  assign glyph  = hex_glyph(held);
  assign seg    = dark ? '0 : glyph;
  assign zout_n = !dark;

  AST_FORCE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    !force_n |-> (seg == '0) && !zout_n); // R8
  AST_RIPPLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!zin_n && held == '0) |-> (seg == '0) && !zout_n); // R5
  AST_LIT_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    zout_n |-> (seg != '0)); // R2
endmodule

// File: tb/tb_hexdisp_digit.sv
module tb_hexdisp_digit;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0;
  logic rst_n, track_n, zin_n, force_n;
  logic [3:0] din;
  logic [6:0] seg;
  logic zout_n;
  int checks = 0, fails = 0;

  // eight-stage chain, index 7 = most significant integer digit
  logic [3:0] cdig [8];
  logic [6:0] cseg [8];
  logic [7:0] czin, czout;

  always #(CLK_PERIOD/2) clk = ~clk;

  hexdisp_digit dut (
    .clk(clk), .rst_n(rst_n), .track_n(track_n), .din(din),
    .zin_n(zin_n), .force_n(force_n), .seg(seg), .zout_n(zout_n)
  );

  // integer chain 7->6->5->4, stage 4 open; fraction chain 0->1->2->3, stage 3 open
  assign czin[7] = 1'b0;
  assign czin[6] = czout[7];
  assign czin[5] = czout[6];
  assign czin[4] = 1'b1;
  assign czin[3] = 1'b1;
  assign czin[2] = czout[1];
  assign czin[1] = czout[0];
  assign czin[0] = 1'b0;

  for (genvar i = 0; i < 8; i++) begin : g_chain
    hexdisp_digit u_st (
      .clk(clk), .rst_n(rst_n), .track_n(track_n), .din(cdig[i]),
      .zin_n(czin[i]), .force_n(1'b1), .seg(cseg[i]), .zout_n(czout[i])
    );
  end

  function automatic logic [6:0] exp_glyph(input logic [3:0] v);
    logic [6:0] t [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                           7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
    return t[v];
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 0; track_n = 1; din = 4'h9; zin_n = 1; force_n = 1;
    for (int i = 0; i < 8; i++) cdig[i] = 4'h5;
    step(); step();
    rst_n = 1; @(negedge clk);
    check("R1 seg", {1'b0, seg}, {1'b0, exp_glyph(4'h0)});
    check("R1 zout", {7'b0, zout_n}, 8'h01);
  endtask

  task automatic t_glyphs();
    track_n = 0; zin_n = 1; force_n = 1;
    for (int v = 0; v < 16; v++) begin
      din = v[3:0];
      step();
      check("R2/R3 glyph", {1'b0, seg}, {1'b0, exp_glyph(v[3:0])});
    end
  endtask

  task automatic t_hold();
    track_n = 0; din = 4'hA; step();
    track_n = 1;
    for (int v = 0; v < 4; v++) begin
      din = v[3:0]; step();
      check("R4 hold", {1'b0, seg}, {1'b0, exp_glyph(4'hA)});
    end
    track_n = 0; step();
    check("R3 reload", {1'b0, seg}, {1'b0, exp_glyph(4'h3)});
  endtask

  task automatic t_ripple();
    track_n = 0; din = 4'h0; zin_n = 0; step();
    check("R5 seg", {1'b0, seg}, 8'h00);
    check("R5 zout", {7'b0, zout_n}, 8'h00);
    zin_n = 1; #1;
    check("R6 seg", {1'b0, seg}, {1'b0, exp_glyph(4'h0)});
    check("R6 zout", {7'b0, zout_n}, 8'h01);
    zin_n = 0; din = 4'h8; step();
    check("R7 seg", {1'b0, seg}, {1'b0, exp_glyph(4'h8)});
    check("R7 zout", {7'b0, zout_n}, 8'h01);
  endtask

  task automatic t_force();
    zin_n = 1; din = 4'hF; step();
    force_n = 0; #1;
    check("R8 seg", {1'b0, seg}, 8'h00);
    check("R8 zout", {7'b0, zout_n}, 8'h00);
    force_n = 1; #1;
    check("R8 release", {1'b0, seg}, {1'b0, exp_glyph(4'hF)});
  endtask

  task automatic t_chain();
    logic [3:0] num [8] = '{4'h0, 4'h0, 4'h3, 4'h0, 4'h0, 4'h6, 4'h0, 4'h0};
    logic [7:0] lit;
    for (int i = 0; i < 8; i++) cdig[i] = num[i];
    track_n = 0; step(); track_n = 1; #1;
    for (int i = 0; i < 8; i++) lit[i] = (cseg[i] != 7'h0);
    check("R9 lit mask", lit, 8'b0011_1100);
    check("R9 digit6", {1'b0, cseg[5]}, {1'b0, exp_glyph(4'h6)});
    check("R9 digit3", {1'b0, cseg[2]}, {1'b0, exp_glyph(4'h3)});
  endtask

  initial begin
    fork
      begin
        t_reset(); t_glyphs(); t_hold(); t_ripple(); t_force(); t_chain();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule